// File: doc/BRIEF.md
# Core Event Latch and Nesting Controller

This block stands between a vector of general-purpose event inputs and a processor core. Each input is brought into the clock domain and its rising edges are held in a latch register. A per-event mask decides whether a latched event may be serviced. The most urgent serviceable event is offered to the core, where the lowest index is the most urgent. When the core takes it, the event moves from the latch into a pending/active register. That register records every event now being serviced, including events nested inside each other.

An event is offered only when it outranks every event already active, so a handler can be interrupted by something more urgent but not by something less urgent. A return strobe retires the innermost active event, which is the most urgent active one. Software reaches the latch, mask and pending registers through a small register port that only works in supervisor mode. Software can cancel a latched event only while that event is masked. Two strobes open and close the whole dispatch path at once.

Top module: `evt_nest_ctrl`

## Requirements
- R1: After reset the latch, mask and pending registers read 0, global enable is off and `dispValid` is 0.
- R2: A rising edge on `evtIn[k]` sets latch bit k exactly two clock edges after the input is first sampled high. An input that stays high is not latched again.
- R3: `dispIdx` is the lowest index whose latch and mask bits are both 1. When `dispValid` and `dispAck` are high at a clock edge, pending bit `dispIdx` is set and latch bit `dispIdx` is cleared at that edge, and no other pending bit becomes set.
- R4: A new rising edge whose latch-set cycle falls in the accept cycle of the same event leaves that latch bit set, so the second event is queued.
- R5: A mask bit of 0 keeps its event from being offered, but the event still latches. A mask bit of 1 lets it be offered.
- R6: A supervisor write to the latch register (`regSel`=0) clears each bit written as 1 whose mask bit is 0. Latch bits whose mask bit is 1 are unchanged.
- R7: Register select codes are 0 latch, 1 mask, 2 pending and 3 unused (reads 0). With `supervisor` low, `regRdata` is 0 and writes have no effect. The pending register is never written by software.
- R8: `gieSet` turns global enable on and `gieClr` turns it off. When both are high in the same cycle, off wins. While enable is off, `dispValid` is 0.
- R9: `dispValid` is 1 only when the candidate index is below the lowest set pending bit, or no pending bit is set.
- R10: `retStrobe` clears the lowest set pending bit at the next edge. An accept in the same cycle is applied as well.
- R11: At least three clock edges pass from an input rising to its pending bit reading 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtIn | input | NUM_EVT | Raw event inputs |
| regSel | input | 2 | Register select: 0 latch, 1 mask, 2 pending, 3 none |
| regWr | input | 1 | Register write strobe |
| regWdata | input | NUM_EVT | Register write data |
| supervisor | input | 1 | Supervisor-mode qualifier for reads and writes |
| gieSet | input | 1 | Global enable strobe |
| gieClr | input | 1 | Global disable strobe |
| dispAck | input | 1 | Core accepts the offered event |
| retStrobe | input | 1 | Return from the innermost active event |
| regRdata | output | NUM_EVT | Register read data, 0 outside supervisor mode |
| dispValid | output | 1 | An event is offered to the core |
| dispIdx | output | $clog2(NUM_EVT) | Index of the offered event |

## Verification
Two pairs of actions can land on the same clock edge. The first pair is the accept of an event and a fresh edge latching on that same input. The bench pulses an input, then raises it again so that its latch-set cycle matches the cycle in which the core acknowledges. It then expects both the pending bit and the latch bit to be set. The second pair is a return and an accept together. The bench raises a more urgent event under an active one, drives `dispAck` and `retStrobe` in one cycle, and expects the pending register to hold only the new event.

// File: rtl/evt_pkg.sv
package evt_pkg;

  typedef enum logic [1:0] {
    SEL_LATCH = 2'd0,
    SEL_MASK  = 2'd1,
    SEL_PEND  = 2'd2,
    SEL_NONE  = 2'd3
  } regSel_e;

  // strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic accept;   // core takes the candidate event
    logic retire;   // innermost active event completes
    logic cancel;   // supervisor write to the latch register
    logic maskWr;   // supervisor write to the mask register
  } evtStrobe_t;

endpackage

// File: rtl/evt_first_set.sv
module evt_first_set #(
  parameter int N = 32
) (
  input  logic [N-1:0]         vec,
  output logic                 found,
  output logic [$clog2(N)-1:0] idx,
  output logic [N-1:0]         oneHot
);
  localparam int W = $clog2(N);
  localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

  // scan from the top so the lowest set index wins
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = W'(i);
      end
    end
    oneHot = found ? (ONE << idx) : '0;
  end
endmodule

// File: rtl/evt_dp.sv
module evt_dp
  import evt_pkg::*;
#(
  parameter int NUM_EVT = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_EVT-1:0]         evtIn,
  input  logic [1:0]                 regSel,
  input  logic [NUM_EVT-1:0]         regWdata,
  input  logic                       supervisor,
  input  evtStrobe_t                 strb,
  output logic [NUM_EVT-1:0]         regRdata,
  output logic                       canDispatch,
  output logic [$clog2(NUM_EVT)-1:0] candIdx
);
  localparam int IDX_W = $clog2(NUM_EVT);
  localparam logic [NUM_EVT-1:0] ONE = {{(NUM_EVT-1){1'b0}}, 1'b1};

  logic [NUM_EVT-1:0] sync0, sync1;
  logic [NUM_EVT-1:0] latchReg, maskReg, pendReg;
  logic [NUM_EVT-1:0] riseVec, candVec, candOneHot, pendOneHot;
  logic [NUM_EVT-1:0] acceptVec, retireVec, cancelVec;
  logic               candFound, pendFound;
  logic [IDX_W-1:0]   pendIdx;

  // two stages bring the inputs in; an edge shows as first-stage high, second low
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sync0 <= '0;
      sync1 <= '0;
    end else begin
      sync0 <= evtIn;
      sync1 <= sync0;
    end
  end
  assign riseVec = sync0 & ~sync1;

  assign candVec = latchReg & maskReg;

  evt_first_set #(.N(NUM_EVT)) u_candPick (
    .vec(candVec), .found(candFound), .idx(candIdx), .oneHot(candOneHot)
  );

  evt_first_set #(.N(NUM_EVT)) u_pendPick (
    .vec(pendReg), .found(pendFound), .idx(pendIdx), .oneHot(pendOneHot)
  );

  // nesting rule: only a strictly more urgent event may enter
  assign canDispatch = candFound && (!pendFound || (candIdx < pendIdx));

  assign acceptVec = strb.accept ? candOneHot : '0;
  assign retireVec = strb.retire ? pendOneHot : '0;
  assign cancelVec = strb.cancel ? (regWdata & ~maskReg) : '0;

  // a fresh edge wins over both accept and cancel
  always_ff @(posedge clk) begin
    if (!rstN) begin
      latchReg <= '0;
      maskReg  <= '0;
      pendReg  <= '0;
    end else begin
      latchReg <= (latchReg & ~acceptVec & ~cancelVec) | riseVec;
      pendReg  <= (pendReg & ~retireVec) | acceptVec;
      if (strb.maskWr) maskReg <= regWdata;
    end
  end

  always_comb begin
    regRdata = '0;
    if (supervisor) begin
      case (regSel_e'(regSel))
        SEL_LATCH: regRdata = latchReg;
        SEL_MASK:  regRdata = maskReg;
        SEL_PEND:  regRdata = pendReg;
        default:   regRdata = '0;
      endcase
    end
  end

  // R3: at most one pending bit rises per edge
  p_single_entry_r3: assert property (@(posedge clk) disable iff (!rstN)
    $countones(pendReg & ~$past(pendReg)) <= 1);

  // R3: an accepted latch bit is gone unless a new edge arrived with it
  p_accept_clears_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.accept |=> ((latchReg & $past(acceptVec) & ~$past(riseVec)) == '0));

  // R6: a latch bit only falls through accept or a cancel of a masked bit
  p_latch_fall_legal_r6: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(latchReg) & ~latchReg & ~$past(acceptVec) & ~$past(cancelVec)) == '0));

  // R9: a newly entered event is the most urgent active one
  p_nest_order_r9: assert property (@(posedge clk) disable iff (!rstN)
    strb.accept |=> ((pendReg & ($past(candOneHot) - ONE)) == '0));

  // R10: a lone return drops the innermost active bit
  p_ret_clears_r10: assert property (@(posedge clk) disable iff (!rstN)
    (strb.retire && !strb.accept && pendFound) |=> !pendReg[$past(pendIdx)]);

  // R7: outside supervisor mode the mask does not move and reads are blank
  p_user_mask_stable_r7: assert property (@(posedge clk) disable iff (!rstN)
    !supervisor |=> $stable(maskReg));
  p_user_read_blank_r7: assert property (@(posedge clk) disable iff (!rstN)
    !supervisor |-> (regRdata == '0));

endmodule

// File: rtl/evt_ctl.sv
module evt_ctl
  import evt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] regSel,
  input  logic       regWr,
  input  logic       supervisor,
  input  logic       gieSet,
  input  logic       gieClr,
  input  logic       dispAck,
  input  logic       retStrobe,
  input  logic       canDispatch,
  output evtStrobe_t strb,
  output logic       dispValid
);
  logic gieOn;
  logic supWr;

  // disable dominates a simultaneous enable
  always_ff @(posedge clk) begin
    if (!rstN)       gieOn <= 1'b0;
    else if (gieClr) gieOn <= 1'b0;
    else if (gieSet) gieOn <= 1'b1;
  end

  assign dispValid = gieOn & canDispatch;
  assign supWr     = regWr & supervisor;

  always_comb begin
    strb        = '0;
    strb.accept = dispValid & dispAck;
    strb.retire = retStrobe;
    strb.cancel = supWr && (regSel_e'(regSel) == SEL_LATCH);
    strb.maskWr = supWr && (regSel_e'(regSel) == SEL_MASK);
  end

  // R8: a disable strobe closes dispatch from the next cycle
  p_disable_blocks_r8: assert property (@(posedge clk) disable iff (!rstN)
    (gieClr && !gieSet) |=> !dispValid);
  p_both_strobes_r8: assert property (@(posedge clk) disable iff (!rstN)
    (gieClr && gieSet) |=> !dispValid);

endmodule

// File: rtl/evt_nest_ctrl.sv
module evt_nest_ctrl
  import evt_pkg::*;
#(
  parameter int NUM_EVT = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_EVT-1:0]         evtIn,
  input  logic [1:0]                 regSel,
  input  logic                       regWr,
  input  logic [NUM_EVT-1:0]         regWdata,
  input  logic                       supervisor,
  input  logic                       gieSet,
  input  logic                       gieClr,
  input  logic                       dispAck,
  input  logic                       retStrobe,
  output logic [NUM_EVT-1:0]         regRdata,
  output logic                       dispValid,
  output logic [$clog2(NUM_EVT)-1:0] dispIdx
);
  evtStrobe_t strb;
  logic       canDispatch;

  evt_ctl u_ctl (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWr(regWr),
    .supervisor(supervisor), .gieSet(gieSet), .gieClr(gieClr),
    .dispAck(dispAck), .retStrobe(retStrobe), .canDispatch(canDispatch),
    .strb(strb), .dispValid(dispValid)
  );

  evt_dp #(.NUM_EVT(NUM_EVT)) u_dp (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .regSel(regSel),
    .regWdata(regWdata), .supervisor(supervisor), .strb(strb),
    .regRdata(regRdata), .canDispatch(canDispatch), .candIdx(dispIdx)
  );
endmodule

// File: tb/sim_evt_nest_ctrl.sv
module sim_evt_nest_ctrl;
  localparam int CLK_P = 10;
  localparam logic [1:0] S_LAT = 2'd0, S_MSK = 2'd1, S_PND = 2'd2, S_NON = 2'd3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] evtIn = '0, regWdata = '0;
  logic [1:0]  regSel = '0;
  logic        regWr = 1'b0, supervisor = 1'b0, gieSet = 1'b0, gieClr = 1'b0;
  logic        dispAck = 1'b0, retStrobe = 1'b0;
  logic [31:0] regRdata;
  logic        dispValid;
  logic [4:0]  dispIdx;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_P / 2) clk = ~clk;

  evt_nest_ctrl u0 (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .regSel(regSel), .regWr(regWr),
    .regWdata(regWdata), .supervisor(supervisor), .gieSet(gieSet),
    .gieClr(gieClr), .dispAck(dispAck), .retStrobe(retStrobe),
    .regRdata(regRdata), .dispValid(dispValid), .dispIdx(dispIdx)
  );

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] v);
    regSel = sel;
    #1;
    v = regRdata;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    regSel = sel; regWdata = d; regWr = 1'b1;
    step();
    regWr = 1'b0; regWdata = '0;
  endtask

  task automatic ack();
    dispAck = 1'b1; step(); dispAck = 1'b0;
  endtask

  task automatic ret();
    retStrobe = 1'b1; step(); retStrobe = 1'b0;
  endtask

  function automatic int lowest(input logic [31:0] v);
    for (int i = 31; i >= 0; i--) if (v[i]) lowest = i;
    if (v == 0) lowest = -1;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, remain, pat;
    repeat (3) step();
    rstN = 1'b1;
    supervisor = 1'b1;
    step();
    // reset state
    rd(S_LAT, v); chk("R1 latch", v, 0);
    rd(S_MSK, v); chk("R1 mask", v, 0);
    rd(S_PND, v); chk("R1 pend", v, 0);
    chk("R1 dispValid", 32'(dispValid), 0);

    wr(S_MSK, 32'hFFFF_FFFF);
    gieSet = 1'b1; step(); gieSet = 1'b0;

    // sweep every event through latch, accept and return
    for (int k = 0; k < 32; k++) begin
      evtIn[k] = 1'b1;
      step();
      rd(S_LAT, v); chk("R2 not yet latched", v, 0);
      step();
      rd(S_LAT, v); chk("R2 latched", v, 32'h1 << k);
      chk("R3 valid", 32'(dispValid), 1);
      chk("R3 idx", 32'(dispIdx), 32'(k));
      ack();
      rd(S_PND, v); chk("R11 pending after three edges", v, 32'h1 << k);
      rd(S_LAT, v); chk("R3 latch cleared", v, 0);
      step(); step();
      rd(S_LAT, v); chk("R2 held level not relatched", v, 0);
      evtIn[k] = 1'b0;
      ret();
      rd(S_PND, v); chk("R10 pending cleared", v, 0);
      step(); step();
      chk("R10 idle", 32'(dispValid), 0);
    end

    // priority and nesting over multi-bit patterns
    for (int p = 0; p < 8; p++) begin
      pat = (32'hF0F0_0000 >> (p * 3)) | (32'h1 << (31 - p));
      evtIn = pat;
      step(); step();
      evtIn = '0;
      remain = pat;
      while (remain != 0) begin
        chk("R3 lowest wins", 32'(dispIdx), 32'(lowest(remain)));
        chk("R3 offered", 32'(dispValid), 1);
        ack();
        remain = remain & ~(32'h1 << lowest(remain));
        if (remain != 0) chk("R9 less urgent blocked", 32'(dispValid), 0);
        ret();
      end
      rd(S_PND, v); chk("R10 drained", v, 0);
      step(); step();
    end

    // explicit nesting: 10 active, 20 waits, 3 nests
    evtIn[10] = 1'b1; step(); step(); ack(); evtIn[10] = 1'b0;
    evtIn[20] = 1'b1; step(); step(); evtIn[20] = 1'b0;
    chk("R9 lower urgency waits", 32'(dispValid), 0);
    evtIn[3] = 1'b1; step(); step(); evtIn[3] = 1'b0;
    chk("R9 nest valid", 32'(dispValid), 1);
    chk("R9 nest idx", 32'(dispIdx), 3);
    ack();
    rd(S_PND, v); chk("R9 two nested", v, (32'h1 << 3) | (32'h1 << 10));
    ret();
    rd(S_PND, v); chk("R10 innermost cleared", v, 32'h1 << 10);
    chk("R9 still blocked", 32'(dispValid), 0);
    ret();
    chk("R9 released", 32'(dispIdx), 20);
    ack();
    evtIn[5] = 1'b1; step(); step(); evtIn[5] = 1'b0;
    dispAck = 1'b1; retStrobe = 1'b1; step(); dispAck = 1'b0; retStrobe = 1'b0;
    rd(S_PND, v); chk("R10 return with accept", v, 32'h1 << 5);
    ret(); step(); step();

    // same-edge accept and new rising edge
    evtIn[4] = 1'b1; step();
    evtIn[4] = 1'b0; step();
    chk("R4 offered", 32'(dispIdx), 4);
    evtIn[4] = 1'b1; step();
    ack();
    rd(S_PND, v); chk("R4 pending", v, 32'h1 << 4);
    rd(S_LAT, v); chk("R4 requeued", v, 32'h1 << 4);
    evtIn[4] = 1'b0;
    ret();
    chk("R4 second offer", 32'(dispValid), 1);
    ack(); ret(); step(); step();

    // masking, global enable and cancel
    wr(S_MSK, ~(32'h1 << 7));
    gieClr = 1'b1; step(); gieClr = 1'b0;
    evtIn[7] = 1'b1; evtIn[9] = 1'b1; step(); step();
    evtIn = '0;
    rd(S_LAT, v); chk("R5 masked still latches", v, (32'h1 << 7) | (32'h1 << 9));
    chk("R8 disabled", 32'(dispValid), 0);
    gieSet = 1'b1; step(); gieSet = 1'b0;
    chk("R5 masked skipped", 32'(dispIdx), 9);
    chk("R8 enabled", 32'(dispValid), 1);
    supervisor = 1'b0;
    wr(S_LAT, 32'hFFFF_FFFF);
    supervisor = 1'b1;
    rd(S_LAT, v); chk("R7 user cancel ignored", v, (32'h1 << 7) | (32'h1 << 9));
    wr(S_LAT, 32'hFFFF_FFFF);
    rd(S_LAT, v); chk("R6 only masked cancelled", v, 32'h1 << 9);
    gieSet = 1'b1; gieClr = 1'b1; step(); gieSet = 1'b0; gieClr = 1'b0;
    chk("R8 off wins", 32'(dispValid), 0);
    gieSet = 1'b1; step(); gieSet = 1'b0;
    chk("R8 reopened", 32'(dispIdx), 9);
    ack(); ret();
    wr(S_MSK, 32'hFFFF_FFFF);

    // supervisor-only access and read decode
    supervisor = 1'b0;
    rd(S_MSK, v); chk("R7 user read mask", v, 0);
    rd(S_LAT, v); chk("R7 user read latch", v, 0);
    wr(S_MSK, 32'h0);
    supervisor = 1'b1;
    rd(S_MSK, v); chk("R7 user write ignored", v, 32'hFFFF_FFFF);
    wr(S_PND, 32'hFFFF_FFFF);
    rd(S_PND, v); chk("R7 pending not writable", v, 0);
    rd(S_NON, v); chk("R7 unused select", v, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule